// File: doc/BRIEF.md
# Bounded Vector String Copy Engine

This block copies a zero-terminated byte string from one memory area to another and never moves more than a given number of bytes. It uses strncpy semantics. It works in vector iterations. Each iteration starts by choosing a vector length, which is the smaller of the bytes still owed and the maximum vector length `MAXVL`. The engine then loads up to that many source bytes speculatively. The length is cut in two places. The first cut is where a load would touch an address at or above the readable limit. The second cut is just after the first zero byte, so the zero byte itself is kept. The engine stores exactly the surviving bytes and moves both pointers on by that length.

When a zero byte ends the copy, the engine fills the rest of the destination with zero bytes, again in chunks of at most `MAXVL`, until `n` bytes have been written in total. If an iteration cannot load even its first byte, the engine stops and reports an error and does not retry. The memory port makes at most one byte access per cycle. A one-cycle completion pulse carries the error flag and the number of string bytes copied, not counting the terminator.

Top module: `vstrcpy_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `mem_re` and `mem_we` are all 0.
- R2: Each vector iteration loads at most `MAXVL` bytes. No more than `MAXVL` read cycles follow one another without a gap.
- R3: A read is never issued at an address at or above `lim_addr`. If the first load of an iteration would fault, the engine finishes with `err` set and does not zero-fill.
- R4: For a string of length k < n (the zero byte at offset k), destination bytes 0..k hold the source bytes including the zero, and `copied` equals k.
- R5: Bytes below the limit and before the first zero are copied unchanged to the destination at the same offset. If no zero byte and no fault occur within n bytes, `copied` equals n.
- R6: After a zero byte ends the copy, destination offsets k+1..n-1 are written with 0x00. On success exactly n bytes are written.
- R7: A start with `count` = 0 raises `done` on the next cycle with no memory access, `copied` = 0 and `err` = 0.
- R8: `mem_re` and `mem_we` are never asserted in the same cycle.
- R9: `done` is high for exactly one cycle per command, and `busy` is high from the cycle after `start` until `done`.
- R10: No write lands outside the destination offsets 0..n-1. On error exactly `copied` bytes are written.
- R11: The source and destination pointers move only at the end of a whole load or store run, by the run length, and not once per element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy; taken only when idle |
| src_addr | input | AW | Source string start address |
| dst_addr | input | AW | Destination start address |
| count | input | CW | Maximum bytes n to write |
| lim_addr | input | AW | First unreadable address; reads at or above it fault |
| mem_addr | output | AW | Byte address of the current access |
| mem_re | output | 1 | Read strobe; data is returned in the same cycle |
| mem_rdata | input | 8 | Read data |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Copy stopped on an unloadable first element |
| copied | output | CW | String bytes copied, terminator excluded |

## Verification
The hardest cases to reach are a fault and a terminator that fall inside the same vector chunk. The other hard case is a fault that lands exactly on a chunk boundary, so that the next iteration loads nothing. The bench places the source at a fixed address. It sweeps the terminator offset, the count and the limit address jointly over all small values, which puts faults and zero bytes at every position inside and across 4-byte chunks. For every combination it predicts the destination image, the write count and the result from a byte-by-byte scan.

// File: rtl/vstrcpy_engine.sv
module vstrcpy_engine #(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int MAXVL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] lim_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] copied
);
  localparam int VW = $clog2(MAXVL + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SET, S_LOAD, S_CMP, S_STORE, S_ZSET, S_ZWR, S_DONE
  } st_t;

  st_t           st;
  logic [AW-1:0] src_q, dst_q, lim_q;
  logic [CW-1:0] rem_q, cp_q;
  logic [VW-1:0] vl_q, idx_q;
  logic          nul_q, err_q;
  logic [7:0]    buf_q [MAXVL];

  logic [VW-1:0] vl_pick, zpos;
  logic          zhit, flt, last;
  logic [AW:0]   rd_full;

  assign vl_pick = (rem_q > CW'(MAXVL)) ? VW'(MAXVL) : VW'(rem_q);
  assign rd_full = {1'b0, src_q} + (AW+1)'(idx_q);
  assign flt     = rd_full >= {1'b0, lim_q};
  assign last    = (idx_q == vl_q - 1'b1);

  always_comb begin
    zhit = 1'b0;
    zpos = '0;
    for (int i = MAXVL - 1; i >= 0; i--)
      if (VW'(i) < vl_q && buf_q[i] == 8'h00) begin
        zhit = 1'b1;
        zpos = VW'(i);
      end
  end

  assign mem_re    = (st == S_LOAD) && !flt;
  assign mem_we    = (st == S_STORE) || (st == S_ZWR);
  assign mem_addr  = (st == S_LOAD) ? rd_full[AW-1:0] : dst_q + AW'(idx_q);
  assign mem_wdata = (st == S_STORE) ? buf_q[idx_q] : 8'h00;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign err       = err_q;
  assign copied    = cp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      src_q <= '0;
      dst_q <= '0;
      lim_q <= '0;
      rem_q <= '0;
      cp_q  <= '0;
      vl_q  <= '0;
      idx_q <= '0;
      nul_q <= 1'b0;
      err_q <= 1'b0;
      for (int i = 0; i < MAXVL; i++) buf_q[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          src_q <= src_addr;
          dst_q <= dst_addr;
          lim_q <= lim_addr;
          rem_q <= count;
          cp_q  <= '0;
          nul_q <= 1'b0;
          err_q <= 1'b0;
          st    <= (count == '0) ? S_DONE : S_SET;
        end
        S_SET: begin
          idx_q <= '0;
          vl_q  <= vl_pick;
          st    <= (rem_q == '0) ? S_DONE : S_LOAD;
        end
        S_LOAD: begin
          if (flt) begin
            idx_q <= '0;
            if (idx_q == '0) begin
              err_q <= 1'b1;
              st    <= S_DONE;
            end else begin
              vl_q <= idx_q;
              st   <= S_CMP;
            end
          end else begin
            buf_q[idx_q] <= mem_rdata;
            if (last) begin
              idx_q <= '0;
              st    <= S_CMP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        S_CMP: begin
          if (zhit) begin
            vl_q  <= zpos + 1'b1;
            nul_q <= 1'b1;
          end
          st <= S_STORE;
        end
        S_STORE: begin
          if (last) begin
            idx_q <= '0;
            src_q <= src_q + AW'(vl_q);
            dst_q <= dst_q + AW'(vl_q);
            rem_q <= rem_q - CW'(vl_q);
            cp_q  <= cp_q + CW'(vl_q) - CW'(nul_q);
            if (!nul_q)                   st <= S_SET;
            else if (rem_q == CW'(vl_q))  st <= S_DONE;
            else                          st <= S_ZSET;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_ZSET: begin
          idx_q <= '0;
          vl_q  <= vl_pick;
          st    <= S_ZWR;
        end
        S_ZWR: begin
          if (last) begin
            idx_q <= '0;
            dst_q <= dst_q + AW'(vl_q);
            rem_q <= rem_q - CW'(vl_q);
            st    <= (rem_q == CW'(vl_q)) ? S_DONE : S_ZSET;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R3
  no_fault_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ({1'b0, mem_addr} < {1'b0, lim_q}));

  // R2
  vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD) |-> (vl_q != '0 && vl_q <= VW'(MAXVL)));

  // R11
  src_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STORE && $past(st) == S_STORE) |-> $stable(src_q));

  // R11
  dst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ZWR && $past(st) == S_ZWR) |-> $stable(dst_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && count == '0) |=> (done && !mem_re && !mem_we));

  // R6
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ZWR) |-> (mem_we && mem_wdata == 8'h00));
endmodule

// File: tb/sim_vstrcpy_engine.sv
module sim_vstrcpy_engine;
  localparam int AW = 8, CW = 8, MAXVL = 4;
  localparam int SRC = 16, DST = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src_addr = AW'(SRC), dst_addr = AW'(DST), lim_addr = '1;
  logic [CW-1:0] count = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_re, mem_we, busy, done, err;
  logic [7:0]    mem_rdata, mem_wdata;
  logic [CW-1:0] copied;

  logic [7:0] mem [256];
  int total = 0, bad = 0;
  int wr_cnt, wr_out, rd_bad, both_bad, run_len, run_bad;
  int lo_dst, hi_dst;

  always #5 clk = ~clk;

  vstrcpy_engine #(.AW(AW), .CW(CW), .MAXVL(MAXVL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .count(count), .lim_addr(lim_addr),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy), .done(done),
    .err(err), .copied(copied));

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt++;
      if (int'(mem_addr) < lo_dst || int'(mem_addr) >= hi_dst) wr_out++;
    end
    if (mem_re) begin
      if (mem_addr >= lim_addr) rd_bad++;
      run_len++;
      if (run_len > MAXVL) run_bad++;
    end else run_len = 0;
    if (mem_re && mem_we) both_bad++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sbyte(input int i, input int p);
    return (i == p) ? 8'h00 : 8'(8'h40 + i);
  endfunction

  task automatic run_one(input int n, input int p, input int lim);
    int k, e_cp, e_wr, cyc;
    bit e_err, e_nul, ok;
    for (int a = 0; a < 256; a++) mem[a] = 8'hA5;
    for (int i = 0; i < 24; i++) mem[SRC + i] = sbyte(i, p);
    wr_cnt = 0; wr_out = 0; rd_bad = 0; both_bad = 0; run_len = 0; run_bad = 0;
    lo_dst = DST; hi_dst = DST + n;
    e_err = 0; e_nul = 0; k = 0;
    while (k < n) begin
      if (SRC + k >= lim) begin e_err = 1; break; end
      if (sbyte(k, p) == 8'h00) begin e_nul = 1; break; end
      k++;
    end
    e_cp = k;
    e_wr = e_err ? k : n;
    @(negedge clk);
    count = CW'(n); lim_addr = AW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: busy from the cycle after start
    check(busy || done, "R9 busy", int'(busy), 1);
    if (n == 0) check(done && wr_cnt == 0 && run_len == 0, "R7 zero count", int'(done), 1);
    cyc = 0;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    check(done, "R9 done seen", int'(done), 1);
    check(int'(copied) == e_cp, e_nul ? "R4 copied" : "R5 copied", int'(copied), e_cp);
    check(err == e_err, "R3 err", int'(err), int'(e_err));
    @(negedge clk);
    check(!done && !busy, "R9 single pulse", int'(done), 0);
    ok = 1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] ex;
      if (e_err) ex = (i < k) ? sbyte(i, p) : 8'hA5;
      else if (e_nul && i > k) ex = 8'h00;
      else ex = sbyte(i, p);
      if (mem[DST + i] !== ex) begin
        ok = 0;
        check(0, (e_nul && i > k) ? "R6 fill byte" : "R5 data byte", int'(mem[DST + i]), int'(ex));
      end
    end
    if (ok) check(1, "R5 data", 0, 0);
    check(mem[DST - 1] == 8'hA5 && mem[DST + n] == 8'hA5 && wr_out == 0,
          "R10 guard", wr_out, 0);
    check(wr_cnt == e_wr, e_err ? "R10 write count" : "R6 write count", wr_cnt, e_wr);
    check(rd_bad == 0, "R3 read limit", rd_bad, 0);
    check(run_bad == 0, "R2 run length", run_bad, 0);
    check(both_bad == 0, "R8 one access", both_bad, 0);
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lims [7] = '{16, 17, 18, 19, 21, 24, 255};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !mem_re && !mem_we, "R1 reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 idle", int'(busy), 0);
    for (int n = 0; n <= 10; n++)
      for (int p = 0; p <= 11; p++)
        for (int li = 0; li < 7; li++)
          run_one(n, p, lims[li]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule